// File: doc/BRIEF.md
# Interval Timer Interrupt Controller

This block is a register-mapped system controller slice. It pairs a reloadable countdown timer with a few interrupt status registers. A plain register bus reaches all of its registers. That bus carries a word address, separate read and write strobes, write data and registered read data. The timer counts down on a coarse tick from a free-running prescaler. It raises a level interrupt when the count runs out. Software re-arms the timer by reading the timer status register; writing a control bit does not re-arm it. An inter-processor interrupt is raised by a request input and cleared by reading its own status register. A local-bus status register reports an externally pending source as an encoded level.

The timer is a three-state machine. `TMR_IDLE` holds a zero count and does nothing. `TMR_RUN` holds a nonzero count and decrements it on each enabled tick. `TMR_DONE` means the count has run out.

The transitions are:
- A write of a nonzero interval value goes to `TMR_RUN`. A write of zero goes to `TMR_IDLE`.
- An enabled tick that takes the count from 1 to 0 goes from `TMR_RUN` to `TMR_DONE` and raises the timer interrupt.
- An acknowledge reloads the count from the reload value. It goes to `TMR_RUN` if the reload value is nonzero, and to `TMR_IDLE` otherwise.

The timer interrupt is held in a flag of its own beside the state. It is set only when the machine enters `TMR_DONE`, and it is cleared only by an acknowledge. A new interval written while the interrupt is pending therefore leaves the interrupt pending.

Register word offsets: 0x00 configuration, 0x04 local-bus status, 0x08 expansion-bus status, 0x0C timer status, 0x10 inter-processor status, 0x14 processor identifier, 0x18 interrupt mask, 0x1C interval value.

Top module: `ivt_irq_ctrl`

## Requirements
- R1: A free-running prescaler, cleared by reset, produces one tick every 2^PRESCALE_BITS clock cycles (default 14). Ticks are never on adjacent cycles.
- R2: A write to offset 0x1C loads both the reload value and the live count with the write data. A read of 0x1C returns the reload value, even while the count is running.
- R3: On a tick, the count decrements only when three conditions all hold: the reload value is nonzero, the count is nonzero, and the mask register at 0x18 is nonzero. While the mask is zero, the count is frozen and no timer interrupt arises.
- R4: When a decrement takes the count to zero, `tmr_irq` goes high on that tick's clock edge. It stays high until it is acknowledged.
- R5: A read of offset 0x0C returns 0, clears `tmr_irq` and reloads the count from the reload value. The timer then fires again after another full interval. With a reload value of zero, the timer stays idle and never fires.
- R6: An acknowledge beats any event in the same cycle. A timer acknowledge overrides a decrement, or an expiry, on the same edge. An inter-processor acknowledge overrides a same-cycle `ipi_set`.
- R7: `ipi_set` high at a clock edge sets `ipi_irq`. A read of offset 0x10 returns 0 and clears `ipi_irq`.
- R8: A read of offset 0x04 returns (LB_LEVEL+1)<<2 while `lb_pending` is high, which is 0x24 for the default level 8. It returns 0 while `lb_pending` is low. The read clears nothing.
- R9: The mask at 0x18 stores and returns all 32 bits. Offset 0x14 returns the CPU_ID parameter, and writes to 0x14 are ignored.
- R10: Reads of 0x00, 0x08, misaligned addresses and offsets above 0x1C return 0. Writes to those addresses change no register.
- R11: Reset clears the mask, the reload value, the count, the read data and both interrupt outputs.
- R12: Read data is registered. It appears on the clock edge that samples `bus_rd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe; a status read acknowledges its source |
| bus_rdata | output | DATA_W (32) | Registered read data |
| lb_pending | input | 1 | Local-bus interrupt pending level |
| ipi_set | input | 1 | Inter-processor interrupt request |
| tmr_irq | output | 1 | Interval timer interrupt level |
| ipi_irq | output | 1 | Inter-processor interrupt level |

## Verification
Two pairs of events can collide on one clock edge. In the first, a read of the timer status register lands on the same edge as the prescaler tick that would take the count to zero. In the second, `ipi_set` lands on the same edge as a read of the inter-processor status register.

The bench finds the tick phase from the edge on which `tmr_irq` rises. From there it counts whole prescaler periods and places its acknowledge on the expiring edge. It then judges that `tmr_irq` stays low, and that the next interrupt comes exactly one full reload interval later. For the second pair, it drives both inputs in the same cycle and requires `ipi_irq` to stay low.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_DONE = 2'd2
    } tmr_state_e;

    typedef enum logic [3:0] {
        SEL_CFG,
        SEL_LB,
        SEL_XBUS,
        SEL_TMR,
        SEL_IPI,
        SEL_ID,
        SEL_MASK,
        SEL_IVAL,
        SEL_NONE
    } reg_sel_e;

    localparam int unsigned NUM_WORDS = 8;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
    parameter int unsigned PRESCALE_BITS = 14
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam logic [PRESCALE_BITS-1:0] LAST = {PRESCALE_BITS{1'b1}};

    logic [PRESCALE_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PRESCALE_BITS'(1);
        end
    end

    assign tick = (cnt_q == LAST);

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mask_nz,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ack,
    output logic [DATA_W-1:0] reload_val,
    output logic              irq
);
    tmr_state_e        state_q, state_d;
    logic [DATA_W-1:0] count_q, count_d;
    logic [DATA_W-1:0] reload_q, reload_d;
    logic              irq_q, irq_d;
    logic              dec_en;

    assign dec_en = tick && mask_nz && (reload_q != '0) && (count_q != '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and datapath
    always_comb begin
        state_d  = state_q;
        count_d  = count_q;
        reload_d = reload_q;
        irq_d    = irq_q;
        if (load) begin
            reload_d = load_data;
            count_d  = load_data;
            state_d  = (load_data != '0) ? TMR_RUN : TMR_IDLE;
        end else if (ack) begin
            irq_d   = 1'b0;
            count_d = reload_q;
            state_d = (reload_q != '0) ? TMR_RUN : TMR_IDLE;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    state_d = TMR_IDLE;
                end
                TMR_RUN: begin
                    if (dec_en) begin
                        count_d = count_q - DATA_W'(1);
                        if (count_q == DATA_W'(1)) begin
                            state_d = TMR_DONE;
                            irq_d   = 1'b1;
                        end
                    end
                end
                TMR_DONE: begin
                    state_d = TMR_DONE;
                end
                default: begin
                    state_d = TMR_IDLE;
                end
            endcase
        end
    end

    // output and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            count_q  <= count_d;
            reload_q <= reload_d;
            irq_q    <= irq_d;
        end
    end

    assign reload_val = reload_q;
    assign irq        = irq_q;

    // R4
    irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(tick));

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack) |=> irq_q);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_q);

    // R6
    ack_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !load) |=> (count_q == $past(reload_q)));

    // R3
    mask_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_nz && !load && !ack) |=> $stable(count_q));

endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned DATA_W   = 32,
    parameter logic [31:0] CPU_ID   = 32'h0,
    parameter int unsigned LB_LEVEL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lb_pending,
    input  logic              ipi_set,
    input  logic [DATA_W-1:0] reload_val,
    output logic              mask_nz,
    output logic              tmr_ack,
    output logic              ival_load,
    output logic              ipi_irq
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] LB_CODE = DATA_W'((LB_LEVEL + 1) << 2);

    reg_sel_e          sel;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_mux;
    logic              ipi_q;
    logic              ipi_ack;

    assign word_idx = bus_addr[ADDR_W-1:2];

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00 && word_idx < IDX_W'(NUM_WORDS)) begin
            unique case (word_idx[2:0])
                3'd0: sel = SEL_CFG;
                3'd1: sel = SEL_LB;
                3'd2: sel = SEL_XBUS;
                3'd3: sel = SEL_TMR;
                3'd4: sel = SEL_IPI;
                3'd5: sel = SEL_ID;
                3'd6: sel = SEL_MASK;
                3'd7: sel = SEL_IVAL;
                default: sel = SEL_NONE;
            endcase
        end
    end

    assign tmr_ack   = bus_rd && (sel == SEL_TMR);
    assign ipi_ack   = bus_rd && (sel == SEL_IPI);
    assign ival_load = bus_wr && (sel == SEL_IVAL);

    always_comb begin
        unique case (sel)
            SEL_LB:   rd_mux = lb_pending ? LB_CODE : '0;
            SEL_ID:   rd_mux = DATA_W'(CPU_ID);
            SEL_MASK: rd_mux = mask_q;
            SEL_IVAL: rd_mux = reload_val;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            rdata_q <= '0;
            ipi_q   <= 1'b0;
        end else begin
            if (bus_wr && sel == SEL_MASK) begin
                mask_q <= bus_wdata;
            end
            if (bus_rd) begin
                rdata_q <= rd_mux;
            end
            if (ipi_ack) begin
                ipi_q <= 1'b0;
            end else if (ipi_set) begin
                ipi_q <= 1'b1;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign mask_nz   = (mask_q != '0);
    assign ipi_irq   = ipi_q;

    // R7
    ipi_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipi_ack |=> !ipi_q);

    // R7
    ipi_set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_set && !ipi_ack) |=> ipi_q);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata_q));

endmodule

// File: rtl/ivt_irq_ctrl.sv
module ivt_irq_ctrl #(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned PRESCALE_BITS = 14,
    parameter logic [31:0] CPU_ID        = 32'h0,
    parameter int unsigned LB_LEVEL      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lb_pending,
    input  logic              ipi_set,
    output logic              tmr_irq,
    output logic              ipi_irq
);
    logic              tick;
    logic              mask_nz;
    logic              tmr_ack;
    logic              ival_load;
    logic [DATA_W-1:0] reload_val;

    ivt_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    ivt_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CPU_ID   (CPU_ID),
        .LB_LEVEL (LB_LEVEL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .lb_pending (lb_pending),
        .ipi_set    (ipi_set),
        .reload_val (reload_val),
        .mask_nz    (mask_nz),
        .tmr_ack    (tmr_ack),
        .ival_load  (ival_load),
        .ipi_irq    (ipi_irq)
    );

    ivt_timer #(.DATA_W(DATA_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .mask_nz    (mask_nz),
        .load       (ival_load),
        .load_data  (bus_wdata),
        .ack        (tmr_ack),
        .reload_val (reload_val),
        .irq        (tmr_irq)
    );

endmodule

// File: tb/ivt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ivt_irq_ctrl_tb;
    localparam int unsigned PB     = 4;
    localparam int unsigned PER    = 1 << PB;
    localparam logic [31:0] MY_ID  = 32'h0000_00A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        lb_pending = 1'b0;
    logic        ipi_set = 1'b0;
    logic        tmr_irq;
    logic        ipi_irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       req_q[$];

    always #5 clk = ~clk;

    ivt_irq_ctrl #(
        .PRESCALE_BITS (PB),
        .CPU_ID        (MY_ID)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .lb_pending (lb_pending),
        .ipi_set    (ipi_set),
        .tmr_irq    (tmr_irq),
        .ipi_irq    (ipi_irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); req_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: compares each read result with the scoreboard entry
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk(bus_rdata, 32'hFFFF_FFFF, "R12 unexpected read");
                end else begin
                    chk(bus_rdata, exp_q.pop_front(), req_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int waited;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({31'b0, tmr_irq}, 32'd0, "R11 tmr_irq in reset");
        chk({31'b0, ipi_irq}, 32'd0, "R11 ipi_irq in reset");
        chk(bus_rdata, 32'd0, "R11 rdata in reset");
        rst_n = 1'b1;
        bus_read(12'h018, 32'd0, "R11 mask after reset");
        bus_read(12'h01C, 32'd0, "R11 reload after reset");

        // R9 mask and id
        bus_write(12'h018, 32'hDEAD_BEEF);
        bus_read(12'h018, 32'hDEAD_BEEF, "R9 mask readback");
        // R12 hold
        repeat (5) @(negedge clk);
        chk(bus_rdata, 32'hDEAD_BEEF, "R12 rdata held");
        bus_write(12'h018, 32'h0);
        bus_read(12'h014, MY_ID, "R9 cpu id");
        bus_write(12'h014, 32'h1234_5678);
        bus_read(12'h014, MY_ID, "R9 cpu id write ignored");

        // R8 local-bus status
        bus_read(12'h004, 32'd0, "R8 lb idle");
        lb_pending = 1'b1;
        bus_read(12'h004, 32'h24, "R8 lb pending");
        bus_read(12'h004, 32'h24, "R8 lb not cleared");
        lb_pending = 1'b0;

        // R10 unmapped and dummy registers
        bus_read(12'h000, 32'd0, "R10 config reads zero");
        bus_read(12'h008, 32'd0, "R10 xbus reads zero");
        bus_write(12'h040, 32'h5555_AAAA);
        bus_write(12'h01A, 32'h0000_0777);
        bus_read(12'h040, 32'd0, "R10 unmapped reads zero");
        bus_read(12'h018, 32'd0, "R10 mask untouched");
        bus_read(12'h01C, 32'd0, "R10 reload untouched");

        // R3 mask zero freezes, R2 read returns reload
        bus_write(12'h01C, 32'd3);
        repeat (100) @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd0, "R3 frozen while mask zero");
        bus_read(12'h01C, 32'd3, "R2 reload readback");

        // R1/R4 expiry window after enabling
        bus_write(12'h018, 32'd1);
        bus_read(12'h01C, 32'd3, "R2 reload while counting");
        repeat (30) @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd0, "R1 no irq before third tick");
        repeat (17) @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd1, "R4 irq after third tick");
        repeat (40) @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd1, "R4 irq held");

        // R5 acknowledge
        bus_read(12'h00C, 32'd0, "R5 timer status reads zero");
        chk({31'b0, tmr_irq}, 32'd0, "R5 irq cleared by read");

        // R6 collision of acknowledge with expiring tick
        bus_write(12'h01C, 32'd2);
        waited = 0;
        while (tmr_irq !== 1'b1 && waited < 200) begin
            @(posedge clk); #1;
            waited++;
        end
        chk({31'b0, tmr_irq}, 32'd1, "R5 timer fired again");
        // now just after edge E (a tick edge)
        bus_read(12'h00C, 32'd0, "R5 ack at E+1");
        repeat (29) @(negedge clk);
        bus_read(12'h00C, 32'd0, "R6 ack on expiring edge");
        chk({31'b0, tmr_irq}, 32'd0, "R6 ack beats expiry");
        repeat (31) @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd0, "R6 no irq before reload interval");
        @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd1, "R5 periodic refire after reload");

        // R5 reload zero stays idle
        bus_write(12'h01C, 32'd0);
        bus_read(12'h00C, 32'd0, "R5 ack before zero test");
        repeat (5 * PER) @(negedge clk);
        chk({31'b0, tmr_irq}, 32'd0, "R5 zero reload never fires");

        // R7 inter-processor interrupt
        @(negedge clk); ipi_set = 1'b1;
        @(negedge clk); ipi_set = 1'b0;
        chk({31'b0, ipi_irq}, 32'd1, "R7 ipi raised");
        bus_read(12'h010, 32'd0, "R7 ipi status reads zero");
        chk({31'b0, ipi_irq}, 32'd0, "R7 ipi cleared");

        // R6 ipi set and ack on the same edge
        @(negedge clk);
        ipi_set = 1'b1; bus_addr = 12'h010; bus_rd = 1'b1;
        exp_q.push_back(32'd0); req_q.push_back("R6 ipi collision read");
        @(negedge clk);
        ipi_set = 1'b0; bus_rd = 1'b0;
        chk({31'b0, ipi_irq}, 32'd0, "R6 ipi ack beats set");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule